// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block turns a fast reference clock into the two timing strobes a UART needs. The first is a sample tick, which is a one-cycle pulse at the oversampling rate. The second is a bit tick, which is a one-cycle pulse once per serial bit time. The reference can pass straight through, or it can first go through a fixed divide-by-8 stage. A 16-bit clock divider follows, and then a bit divider that counts sample ticks. The resulting bit rate is reference / (prescale × clock_div × (bit_div + 1)).

Software sets the block up through a small write port. That port reaches a mode byte and the two divider values. A write that falls outside a divider's legal range is dropped without any side effect. Any accepted write restarts the whole counter chain, so the first tick after reconfiguration is a full period away. The mode byte also holds the character framing fields. These fields are decoded here only to report the length of one character in bits.

Top module: `uart_rate_gen`

## Requirements
- R1: Mode bit 0 = 1 makes the divider chain advance on one reference cycle in every 8; mode bit 0 = 0 makes it advance on every reference cycle.
- R2: The sample tick is a one-cycle pulse every clock_div advances of the chain, so its period is clock_div × (8 if mode bit 0 else 1) reference cycles.
- R3: The bit tick is a one-cycle pulse after every bit_div + 1 sample ticks, so its period is (bit_div + 1) times the sample period.
- R4: A write with wr_sel = 1 (clock divider) and wr_data = 0 is ignored. Any other such write stores wr_data[15:0].
- R5: A write with wr_sel = 2 (bit divider) and wr_data < 4 is ignored. Any other such write stores wr_data[7:0]; the range test uses the full 32-bit value.
- R6: After reset, clock_div = 0x28B, bit_div = 0x0F and the mode byte is 0. A write with wr_sel = 0 stores wr_data[7:0] as the mode byte, and wr_sel = 3 selects nothing.
- R7: frame_bits = 1 + data + parity + stop. Data comes from mode[2:1]: 3 gives 6, 2 gives 7, and any other value gives 8. Parity comes from mode[5:3]: 0 (even) or 1 (odd) adds 1, and any other value adds 0. Stop comes from mode[7:6]: 3 gives 1, and any other value gives 2.
- R8: Every accepted write clears all counters and both ticks at the writing edge. The first sample tick then comes clock_div chain advances later.
- R9: A bit tick only ever appears in the cycle right after a sample tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Target: 0 mode, 1 clock divider, 2 bit divider, 3 none |
| wr_data | input | 32 | Write value |
| sample_tick | output | 1 | Oversampling strobe |
| bit_tick | output | 1 | Bit-time strobe |
| frame_bits | output | 4 | Character length in bits |
| clk_div_q | output | 16 | Current clock divider |
| bit_div_q | output | 8 | Current bit divider |

## Verification
Several rules are checked by assertions on every cycle. A rejected divider write must leave its register unchanged. In divide-by-8 mode, the prescale enable may never assert on two cycles in a row. An accepted write must leave both ticks low on the next cycle. Ticks may only follow an enabled advance. The actual tick periods, the restart latency, the truncation of accepted values, the reset values and the frame-length decode are shown only by the bench's scenarios, which measure the distance between pulses in reference cycles.

// File: rtl/uart_rate_pkg.sv
// Shared types and decode helpers for the UART bit-rate tick generator.
// Assumes the mode byte layout described in the brief (R7).
package uart_rate_pkg;

    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_CLKDIV = 2'd1,
        SEL_BITDIV = 2'd2,
        SEL_NONE   = 2'd3
    } rate_sel_e;

    // Character length in bits from the mode byte: start + data + parity + stop.
    function automatic logic [3:0] frame_len(input logic [7:0] mode);
        logic [3:0] data_n;
        logic [3:0] par_n;
        logic [3:0] stop_n;
        case (mode[2:1])
            2'd3:    data_n = 4'd6;
            2'd2:    data_n = 4'd7;
            default: data_n = 4'd8;
        endcase
        par_n  = (mode[5:3] <= 3'd1) ? 4'd1 : 4'd0;
        stop_n = (mode[7:6] == 2'd3) ? 4'd1 : 4'd2;
        return 4'd1 + data_n + par_n + stop_n;
    endfunction

endpackage

// File: rtl/rate_cfg_regs.sv
// Configuration registers: mode byte, clock divider and bit divider.
// Range-checks divider writes against the full write value, truncates
// accepted values, and flags any accepted write as a chain restart.
// Assumes wr_en is a single-cycle-per-write strobe in the clk domain.
module rate_cfg_regs
    import uart_rate_pkg::*;
#(
    parameter int WR_W     = 32,
    parameter int CD_W     = 16,
    parameter int BD_W     = 8,
    parameter int MODE_W   = 8,
    parameter int MIN_BD   = 4,
    parameter logic [CD_W-1:0] CD_RST = 16'h028B,
    parameter logic [BD_W-1:0] BD_RST = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WR_W-1:0]   wr_data,
    output logic [MODE_W-1:0] mode_q,
    output logic [CD_W-1:0]   cd_q,
    output logic [BD_W-1:0]   bd_q,
    output logic              restart
);

    logic mode_ok, cd_ok, bd_ok;

    // Decide which register, if any, accepts this cycle's write.
    always_comb begin
        mode_ok = wr_en && (rate_sel_e'(wr_sel) == SEL_MODE);
        cd_ok   = wr_en && (rate_sel_e'(wr_sel) == SEL_CLKDIV) && (wr_data != '0);
        bd_ok   = wr_en && (rate_sel_e'(wr_sel) == SEL_BITDIV)
                  && (wr_data >= WR_W'(MIN_BD));
        restart = mode_ok || cd_ok || bd_ok;
    end

    // Store accepted values, truncated to the register width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            cd_q   <= CD_RST;
            bd_q   <= BD_RST;
        end else begin
            if (mode_ok) mode_q <= wr_data[MODE_W-1:0];
            if (cd_ok)   cd_q   <= wr_data[CD_W-1:0];
            if (bd_ok)   bd_q   <= wr_data[BD_W-1:0];
        end
    end

    assert_cd_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && wr_data == '0) |=> $stable(cd_q));

    assert_bd_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && wr_data < WR_W'(MIN_BD)) |=> $stable(bd_q));

endmodule

// File: rtl/rate_prescaler.sv
// Optional fixed prescaler: when div_on is set, adv pulses once every
// DIV cycles; otherwise adv is held high. Restart realigns the phase.
module rate_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic div_on,
    output logic adv
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Free-running phase counter, cleared by reset and restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    // Advance enable for the downstream divider.
    assign adv = div_on ? (phase == LAST) : 1'b1;

    assert_prescale_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (div_on && adv && !restart) |=> !adv);

endmodule

// File: rtl/rate_divider.sv
// Modulo counter that emits a registered one-cycle tick on the enabled
// advance that completes each group of `modulus` advances.
// Assumes modulus >= 1; restart clears the count and the tick.
module rate_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         en,
    input  logic [W-1:0] modulus,
    output logic         tick
);

    logic [W-1:0] cnt;
    logic         wrap;

    // Terminal count for the current modulus.
    assign wrap = (cnt == modulus - 1'b1);

    // Count enabled advances and register the wrap as the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= en && wrap;
            if (en) cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    assert_tick_follows_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(en));

    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

endmodule

// File: rtl/uart_rate_gen.sv
// UART bit-rate tick generator: prescaler -> clock divider -> bit divider.
// sample_tick period = clock_div * prescale; bit_tick period =
// (bit_div + 1) sample periods. Any accepted config write restarts all stages.
module uart_rate_gen
    import uart_rate_pkg::*;
#(
    parameter int WR_W     = 32,
    parameter int CD_W     = 16,
    parameter int BD_W     = 8,
    parameter int PRESCALE = 8,
    parameter int MIN_BD   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [WR_W-1:0] wr_data,
    output logic            sample_tick,
    output logic            bit_tick,
    output logic [3:0]      frame_bits,
    output logic [CD_W-1:0] clk_div_q,
    output logic [BD_W-1:0] bit_div_q
);

    localparam int MODE_W = 8;
    localparam int BM_W   = BD_W + 1;

    logic [MODE_W-1:0] mode_q;
    logic              restart;
    logic              pre_adv;
    logic [BM_W-1:0]   bit_mod;

    rate_cfg_regs #(
        .WR_W(WR_W), .CD_W(CD_W), .BD_W(BD_W), .MODE_W(MODE_W), .MIN_BD(MIN_BD)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .mode_q(mode_q), .cd_q(clk_div_q),
        .bd_q(bit_div_q), .restart(restart)
    );

    rate_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .div_on(mode_q[0]), .adv(pre_adv)
    );

    rate_divider #(.W(CD_W)) u_clk_div (
        .clk(clk), .rst_n(rst_n), .restart(restart), .en(pre_adv),
        .modulus(clk_div_q), .tick(sample_tick)
    );

    // Bit divider modulus is one more than the stored value.
    assign bit_mod = {1'b0, bit_div_q} + 1'b1;

    rate_divider #(.W(BM_W)) u_bit_div (
        .clk(clk), .rst_n(rst_n), .restart(restart), .en(sample_tick),
        .modulus(bit_mod), .tick(bit_tick)
    );

    // Report character length from the framing fields.
    assign frame_bits = frame_len(mode_q);

    assert_bit_after_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> $past(sample_tick));

endmodule

// File: tb/uart_rate_gen_test.sv
module uart_rate_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic        sample_tick, bit_tick;
    logic [3:0]  frame_bits;
    logic [15:0] clk_div_q;
    logic [7:0]  bit_div_q;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int t_wr = 0;

    uart_rate_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick),
        .frame_bits(frame_bits), .clk_div_q(clk_div_q), .bit_div_q(bit_div_q)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write; t_wr holds the cycle number of the writing edge.
    task automatic do_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        t_wr = cyc;
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic wait_sample(output int at);
        do @(negedge clk); while (!sample_tick);
        at = cyc;
    endtask

    task automatic wait_bit(output int at);
        do @(negedge clk); while (!bit_tick);
        at = cyc;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(clk_div_q == 16'h028B, "R6 clk_div reset", clk_div_q, 16'h028B);
        check(bit_div_q == 8'h0F, "R6 bit_div reset", bit_div_q, 8'h0F);
        check(frame_bits == 4'd12, "R6/R7 reset mode frame", frame_bits, 12);
        check(!sample_tick && !bit_tick, "R6 ticks low", {sample_tick, bit_tick}, 0);
    endtask

    task automatic t_default_rate;
        int a, b;
        wait_sample(a); wait_sample(b);
        check(b - a == 651, "R2 default sample period", b - a, 651);
    endtask

    task automatic t_frames;
        do_write(2'd0, 32'h0000_00E6);   // 6 data, none, 1 stop
        check(frame_bits == 4'd8, "R7 6N1", frame_bits, 8);
        do_write(2'd0, 32'h0000_000C);   // 7 data, odd, 2 stop
        check(frame_bits == 4'd11, "R7 7O2", frame_bits, 11);
        do_write(2'd0, 32'h0000_0042);   // 8 data (code 1), even, 2 stop
        check(frame_bits == 4'd12, "R7 8E2", frame_bits, 12);
        do_write(2'd3, 32'h0000_00E6);   // no target
        check(frame_bits == 4'd12, "R6 sel none", frame_bits, 12);
        do_write(2'd0, 32'h0000_0000);
    endtask

    task automatic t_reject;
        do_write(2'd1, 32'd3);
        do_write(2'd1, 32'd0);
        check(clk_div_q == 16'd3, "R4 zero ignored", clk_div_q, 3);
        do_write(2'd2, 32'd4);
        do_write(2'd2, 32'd3);
        check(bit_div_q == 8'd4, "R5 three ignored", bit_div_q, 4);
        do_write(2'd2, 32'd0);
        check(bit_div_q == 8'd4, "R5 zero ignored", bit_div_q, 4);
    endtask

    task automatic t_truncate;
        do_write(2'd1, 32'h0001_0007);
        check(clk_div_q == 16'd7, "R4 truncate", clk_div_q, 7);
        do_write(2'd2, 32'h0000_0105);
        check(bit_div_q == 8'd5, "R5 truncate", bit_div_q, 5);
    endtask

    task automatic t_rates;
        int a, b, s;
        do_write(2'd1, 32'd3);
        do_write(2'd2, 32'd4);
        s = t_wr;
        wait_sample(a);
        check(a - s == 3, "R8 first sample after write", a - s, 3);
        wait_bit(b);
        check(b - s == 16, "R8/R9 first bit after write", b - s, 16);
        wait_sample(a); wait_sample(b);
        check(b - a == 3, "R2 sample period cd=3", b - a, 3);
        wait_bit(a); wait_bit(b);
        check(b - a == 15, "R3 bit period 3x5", b - a, 15);
    endtask

    task automatic t_prescale;
        int a, b;
        do_write(2'd0, 32'd1);
        wait_sample(a);
        check(a - t_wr == 24, "R1/R8 first sample div8", a - t_wr, 24);
        wait_sample(b);
        check(b - a == 24, "R1 sample period div8", b - a, 24);
        wait_bit(a); wait_bit(b);
        check(b - a == 120, "R1/R3 bit period div8", b - a, 120);
        do_write(2'd0, 32'd0);
    endtask

    task automatic t_cd_one;
        int a, b, n;
        do_write(2'd1, 32'd1);
        wait_sample(a); wait_sample(b);
        check(b - a == 1, "R2 cd=1 every cycle", b - a, 1);
        wait_bit(a); wait_bit(b);
        check(b - a == 5, "R3 bit period 1x5", b - a, 5);
        n = 0;
        repeat (20) begin
            @(negedge clk);
            if (bit_tick) n++;
        end
        check(n == 4, "R3 bit ticks in 20 cycles", n, 4);
    endtask

    initial begin
        t_reset();
        t_default_rate();
        t_frames();
        t_reject();
        t_truncate();
        t_rates();
        t_prescale();
        t_cd_one();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule